// File: doc/BRIEF.md
# T1 Receive Signaling Extractor and Serializer

This block sits on the receive side of a T1 framer. It takes the received serial stream one bit per enabled clock, with a pulse that marks the framing bit and a second pulse that marks the first frame of a multiframe. Robbed-bit signaling is taken from the least significant bit of every channel in the signaling frames. It is gathered into a capture store, and the complete set moves into a held register once per multiframe. The held register is then played out on a serial signaling line. Each output bit lines up with the channel bit that was received in the same enabled cycle.

In ESF framing there are four signaling bits per channel, taken from frames 6, 12, 18 and 24. In D4 framing there are two, taken from frames 6 and 12, and they appear twice in the output nibble. A freeze input keeps the last signaling on the output, and capture goes on underneath it. Extraction cannot be switched off. When a framing pulse is missing, the counters keep running on their own and assume the framing bit after 192 channel bits.

Top module: `t1RxSigSerializer`

## Requirements
- R1: After reset `sigOut` is 0. Every output nibble stays 0 until the first held-register update.
- R2: ESF (`esfMode`=1): the channel LSB received in frames 6, 12, 18 and 24 becomes A, B, C and D. These appear at bits 5, 6, 7 and 8 of that channel's slot, where bit 1 is the first bit after the framing bit for channel 1. They are output through the whole next multiframe.
- R3: D4 (`esfMode`=0): the channel LSB of frames 6 and 12 becomes A and B. Slot bits 5 and 6 carry A and B, and bits 7 and 8 repeat A and B.
- R4: The framing-bit position and bits 1 to 4 of every channel slot output 0.
- R5: The held signaling changes only at the framing bit that starts a new multiframe, and only once a complete multiframe (24 frames ESF, 12 frames D4) has been counted since `mfStart`. It is constant at all other times.
- R6: If `freeze` is 1 at that framing bit, the held signaling is not updated.
- R7: Capture continues while frozen. The first update after `freeze` drops carries the multiframe received most recently.
- R8: `sigOut` updates one clock after a cycle with `bitEn`=1. It holds its value while `bitEn`=0, and inputs in such cycles are ignored.
- R9: `frameSync` together with `mfStart` forces the frame count to 1. A multiframe cut short this way produces no update.
- R10: If no `frameSync` arrives, the framing bit is assumed in the enabled cycle after the 192nd channel bit, and frame counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One received bit is present this cycle |
| frameSync | input | 1 | This bit is the framing bit |
| mfStart | input | 1 | With frameSync: frame 1 of a multiframe |
| rxData | input | 1 | Received serial data bit |
| esfMode | input | 1 | 1 = ESF, 0 = D4 framing |
| freeze | input | 1 | Hold current signaling output |
| sigOut | output | 1 | Serial signaling, aligned to channel slots |

## Verification
A wrong bit or channel counter moves nibbles into the wrong slot or into bits 1 to 4. That shows on `sigOut` within one channel time, 8 enabled bits. A wrong frame count or a wrong capture slot leaves the channel counters intact, so it stays invisible until the next multiframe update. From then on it shows as wrong A/B/C/D values for a whole multiframe. A faulty freeze or update gate shows the same way, one multiframe late. For that reason the bench always uses fresh signaling patterns in every multiframe and compares every cycle.

// File: rtl/t1SigPkg.sv
package t1SigPkg;
  localparam int CH_COUNT    = 24;
  localparam int BITS_PER_CH = 8;
  localparam int SIG_LETTERS = 4;
  localparam int SIG_GAP     = 6;
  localparam int ESF_FRAMES  = 24;
  localparam int D4_FRAMES   = 12;

  localparam int CH_W   = $clog2(CH_COUNT);
  localparam int BIT_W  = $clog2(BITS_PER_CH);
  localparam int FRM_W  = $clog2(ESF_FRAMES + 1);
  localparam int SLOT_W = $clog2(SIG_LETTERS);

  typedef logic [SIG_LETTERS-1:0] sigNibble_t;
  typedef sigNibble_t [CH_COUNT-1:0] sigSet_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              bitValid;  // an enabled bit cycle
    logic              isF;       // framing-bit position
    logic              dataBit;   // a channel bit with known position
    logic [CH_W-1:0]   chan;      // channel of the current bit
    logic [BIT_W-1:0]  bitIdx;    // 0 = first bit of slot
    logic              capEn;     // store rxData into the capture set
    logic [SLOT_W-1:0] capSlot;   // letter index A..D
    logic              xfer;      // capture set -> held set
  } sigStrobe_t;
endpackage

// File: rtl/t1SigCtrl.sv
module t1SigCtrl
  import t1SigPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       frameSync,
  input  logic       mfStart,
  input  logic       esfMode,
  input  logic       freeze,
  output sigStrobe_t strb
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BITS_PER_CH - 1);
  localparam logic [CH_W-1:0]  LAST_CH   = CH_W'(CH_COUNT - 1);
  localparam logic [FRM_W-1:0] GAP_F     = FRM_W'(SIG_GAP);

  logic             locked, expectF, mfSeen;
  logic [CH_W-1:0]  chCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [FRM_W-1:0] frameCnt;

  logic [FRM_W-1:0] lastFrame, nextFrame, quot;
  logic isF, dataBit, atLast, restart, sigFrame;

  always_comb begin
    lastFrame = esfMode ? FRM_W'(ESF_FRAMES) : FRM_W'(D4_FRAMES);
    isF       = bitEn && (frameSync || (locked && expectF));
    dataBit   = bitEn && locked && !isF;
    atLast    = frameCnt >= lastFrame;
    restart   = frameSync && mfStart;
    nextFrame = (restart || atLast) ? FRM_W'(1) : frameCnt + FRM_W'(1);
    quot      = frameCnt / GAP_F;
    sigFrame  = (frameCnt != '0) && ((frameCnt % GAP_F) == '0) && !(frameCnt > lastFrame);

    strb.bitValid = bitEn;
    strb.isF      = isF;
    strb.dataBit  = dataBit;
    strb.chan     = chCnt;
    strb.bitIdx   = bitCnt;
    strb.capEn    = dataBit && sigFrame && (bitCnt == LAST_BIT);
    strb.capSlot  = SLOT_W'(quot - FRM_W'(1));
    strb.xfer     = isF && mfSeen && atLast && !freeze;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked   <= 1'b0;
      expectF  <= 1'b0;
      mfSeen   <= 1'b0;
      chCnt    <= '0;
      bitCnt   <= '0;
      frameCnt <= '0;
    end else if (isF) begin
      locked   <= 1'b1;
      expectF  <= 1'b0;
      chCnt    <= '0;
      bitCnt   <= '0;
      frameCnt <= nextFrame;
      if (restart) mfSeen <= 1'b1;
    end else if (dataBit) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt <= '0;
        if (chCnt == LAST_CH) begin
          chCnt   <= '0;
          expectF <= 1'b1;
        end else begin
          chCnt <= chCnt + CH_W'(1);
        end
      end else begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/t1SigPath.sv
module t1SigPath
  import t1SigPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxData,
  input  logic       esfMode,
  input  sigStrobe_t strb,
  output logic       sigOut,
  output sigSet_t    heldSig
);
  localparam logic [BIT_W-1:0] NIB_START = BIT_W'(BITS_PER_CH - SIG_LETTERS);

  sigSet_t capReg, heldReg;
  logic [SLOT_W-1:0] nibIdx, pickSlot;
  logic nextBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg  <= '0;
      heldReg <= '0;
    end else begin
      for (int c = 0; c < CH_COUNT; c++) begin
        if (strb.capEn && (strb.chan == CH_W'(c)))
          capReg[c][strb.capSlot] <= rxData;
      end
      if (strb.xfer) heldReg <= capReg;
    end
  end

  always_comb begin
    nibIdx   = SLOT_W'(strb.bitIdx - NIB_START);
    // D4 repeats A,B in the upper half of the nibble
    pickSlot = esfMode ? nibIdx : {{(SLOT_W-1){1'b0}}, nibIdx[0]};
    nextBit  = strb.dataBit && (strb.bitIdx >= NIB_START)
               ? heldReg[strb.chan][pickSlot] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sigOut <= 1'b0;
    else if (strb.bitValid) sigOut <= nextBit;
  end

  assign heldSig = heldReg;
endmodule

// File: rtl/t1RxSigSerializer.sv
module t1RxSigSerializer
  import t1SigPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic frameSync,
  input  logic mfStart,
  input  logic rxData,
  input  logic esfMode,
  input  logic freeze,
  output logic sigOut
);
  sigStrobe_t strb;
  sigSet_t    heldSig;

  t1SigCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .mfStart(mfStart), .esfMode(esfMode), .freeze(freeze), .strb(strb)
  );

  t1SigPath u_path (
    .clk(clk), .rstN(rstN), .rxData(rxData), .esfMode(esfMode),
    .strb(strb), .sigOut(sigOut), .heldSig(heldSig)
  );
endmodule

// File: rtl/t1RxSigSerializer_chk.sv
module t1RxSigSerializer_chk
  import t1SigPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       frameSync,
  input logic       freeze,
  input logic       sigOut,
  input sigStrobe_t strb,
  input sigSet_t    heldSig
);
  // R4
  fbit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && frameSync |=> !sigOut);

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataBit && !strb.bitIdx[BIT_W-1] |=> !sigOut);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(sigOut));

  // R5
  update_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.isF |=> $stable(heldSig));

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> $stable(heldSig));
endmodule

bind t1RxSigSerializer t1RxSigSerializer_chk u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
  .freeze(freeze), .sigOut(sigOut), .strb(strb), .heldSig(heldSig)
);

// File: tb/t1RxSigSerializer_tb.sv
`timescale 1ns/1ps
module t1RxSigSerializer_tb;
  logic clk = 1'b0;
  logic rstN, bitEn, frameSync, mfStart, rxData, esfMode, freeze;
  logic sigOut;

  always #2.5 clk = ~clk;

  t1RxSigSerializer u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .mfStart(mfStart), .rxData(rxData), .esfMode(esfMode),
    .freeze(freeze), .sigOut(sigOut)
  );

  // reference model state
  int       vectors = 0, fails = 0;
  int       mPos = 0, mFrame = 0;
  bit       mLocked = 0, mMfSeen = 0, expBit = 0;
  bit [3:0] mCap[24], mOut[24];
  bit       esfV = 1, freezeV = 0, done = 0;
  string    phase = "R1";

  task automatic step(input bit en, input bit fs, input bit mf, input bit d);
    int ch, b, last;
    string tag;
    bitEn = en; frameSync = fs; mfStart = mf; rxData = d;
    esfMode = esfV; freeze = freezeV;
    last = esfV ? 24 : 12;
    tag = "R8";
    if (en) begin
      if (fs || (mLocked && mPos == 193)) begin
        expBit = 0; tag = (!fs && !mf) ? "R10" : "R4";
        if (mMfSeen && mFrame >= last && !freezeV) mOut = mCap;
        if (fs && mf) begin mFrame = 1; mMfSeen = 1; end
        else mFrame = (mFrame >= last) ? 1 : mFrame + 1;
        mLocked = 1; mPos = 1;
      end else if (mLocked) begin
        ch = (mPos - 1) / 8; b = (mPos - 1) % 8;
        if (b < 4) begin expBit = 0; tag = "R4"; end
        else begin
          expBit = esfV ? mOut[ch][b-4] : mOut[ch][(b-4)%2];
          tag = phase;
        end
        if (b == 7 && mFrame > 0 && mFrame % 6 == 0 && mFrame <= last)
          mCap[ch][mFrame/6-1] = d;
        mPos++;
      end else begin
        expBit = 0; tag = phase;
      end
    end
    @(posedge clk); @(negedge clk);
    vectors++;
    if (sigOut !== expBit) begin
      fails++;
      $display("FAIL %s: sigOut=%0b expected %0b (vector %0d)", tag, sigOut, expBit, vectors);
    end
  endtask

  // transmit-side model: one multiframe (or part) with fresh signaling
  task automatic sendMf(input int frames, input bit syncEach, input int gapPct);
    bit [3:0] tx[24];
    int ch, b;
    bit d;
    for (int c = 0; c < 24; c++) tx[c] = 4'($urandom);
    for (int f = 1; f <= frames; f++) begin
      for (int p = 0; p < 193; p++) begin
        if (($urandom % 100) < 32'(gapPct)) step(0, 1'($urandom), 0, 1'($urandom));
        if (p == 0) step(1, (f == 1) || syncEach, f == 1, 1'($urandom));
        else begin
          ch = (p - 1) / 8; b = (p - 1) % 8;
          d = (b == 7 && f % 6 == 0) ? tx[ch][f/6-1] : 1'($urandom);
          step(1, 0, 0, d);
        end
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 24; c++) begin mCap[c] = '0; mOut[c] = '0; end
    rstN = 0; bitEn = 0; frameSync = 0; mfStart = 0; rxData = 0;
    esfMode = 1; freeze = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    vectors++;
    if (sigOut !== 1'b0) begin  // R1 reset state
      fails++; $display("FAIL R1: sigOut=%0b expected 0 after reset", sigOut);
    end
    phase = "R1";  sendMf(24, 1, 0);
    phase = "R2";  sendMf(24, 1, 0); sendMf(24, 1, 0);
    phase = "R5";  sendMf(24, 1, 0); sendMf(24, 1, 0);
    phase = "R8";  sendMf(24, 1, 20);
    phase = "R6";  freezeV = 1; sendMf(24, 1, 0); sendMf(24, 1, 0);
    phase = "R7";  freezeV = 0; sendMf(24, 1, 0); sendMf(24, 1, 0);
    phase = "R3";  esfV = 0; sendMf(12, 1, 0); sendMf(12, 1, 0); sendMf(12, 1, 0);
    phase = "R9";  sendMf(5, 1, 0); sendMf(12, 1, 0); sendMf(12, 1, 0);
    phase = "R10"; esfV = 1; sendMf(24, 0, 0); sendMf(24, 0, 0); sendMf(24, 1, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run still busy after 190000 cycles, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule